// File: doc/BRIEF.md
# Signed-Compare Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. A 3-bit operation code selects one of five functions: bitwise AND, bitwise OR, addition, subtraction or signed set-on-less-than. Operand B passes through a conditional inverter, and the upper bit of the operation code controls both that inverter and the adder's carry-in. Subtraction and the comparison therefore use the same adder as addition.

The block produces the selected result, a flag that shows when the result is all zeros, and a signed overflow flag for the two arithmetic operations. The comparison takes the sign of a minus b and corrects it by the subtraction overflow. The answer is then correct when a minus b falls outside the signed range. A parameter chooses how the adder is built: a ripple chain of one-bit slices, or a single behavioural adder. The operand width is also a parameter, with a default of 32.

Top module: `alu_core`

## Requirements
- R1: Operation code 3'b000 gives result = a AND b, bit by bit.
- R2: Operation code 3'b001 gives result = a OR b, bit by bit.
- R3: Operation code 3'b010 gives result = (a + b) modulo 2^32.
- R4: Operation code 3'b110 gives result = (a - b) modulo 2^32. Bit 2 of the code inverts b and supplies a carry-in of 1.
- R5: Operation code 3'b111 gives result bit 0 = 1 when a < b as two's-complement signed numbers, and 0 otherwise. Bits 31:1 are always 0.
- R6: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R7: For operation code 3'b010, overflow is 1 exactly when a and b have the same sign bit and the result's sign bit differs from it.
- R8: For operation code 3'b110, overflow is 1 exactly when the sign bits of a and b differ and the result's sign bit differs from the sign bit of a.
- R9: The overflow output is 0 for operation codes 3'b000, 3'b001 and 3'b111.
- R10: The unused operation codes 3'b011, 3'b100 and 3'b101 give a result of 0, overflow 0 and zero 1.
- R11: Set-on-less-than stays correct when a - b overflows. For example, a = 0x80000000 and b = 1 gives 1, and a = 0x7FFFFFFF and b = 0xFFFFFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code; bit 2 inverts B and sets the carry-in |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | 1 when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
All three outputs follow their inputs within the same cycle, because the block has no register anywhere. The bench changes the operands and operation code on the falling clock edge. It reads result, zero and overflow a quarter period later, before the next rising edge, so the ripple chain has settled and no value is taken at an edge. Each vector is checked against bench functions. These functions compute the sum and difference in 64-bit signed arithmetic, and they derive overflow from whether that value fits in 32 bits rather than from sign bits.

// File: rtl/alu_pkg.sv
package alu_pkg;
   // Operation codes; bit 2 doubles as the B-invert / carry-in control.
   localparam logic [2:0] ALU_AND = 3'b000;
   localparam logic [2:0] ALU_OR  = 3'b001;
   localparam logic [2:0] ALU_ADD = 3'b010;
   localparam logic [2:0] ALU_SUB = 3'b110;
   localparam logic [2:0] ALU_SLT = 3'b111;

   localparam int unsigned ALU_OP_W = 3;

   function automatic logic alu_op_arith(input logic [2:0] op);
      return (op == ALU_ADD) || (op == ALU_SUB);
   endfunction
endpackage

// File: rtl/alu_slice.sv
// One-bit full-adder slice used for every bit below the sign bit.
module alu_slice (
   input  logic a_i,
   input  logic b_i,
   input  logic cin_i,
   output logic sum_o,
   output logic cout_o
);
   logic half;
   assign half   = a_i ^ b_i;
   assign sum_o  = half ^ cin_i;
   assign cout_o = (a_i & b_i) | (half & cin_i);
endmodule

// File: rtl/alu_sum_chain.sv
// Adder over the full width; RIPPLE selects slice chain or behavioural add.
module alu_sum_chain #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [MSB:0] carry;
         assign carry[0] = cin_i;
         for (genvar i = 0; i < MSB; i++) begin : g_bit
            alu_slice u_slice (
               .a_i   (a_i[i]),
               .b_i   (b_i[i]),
               .cin_i (carry[i]),
               .sum_o (sum_o[i]),
               .cout_o(carry[i+1])
            );
         end
         // Sign slice: no carry-out is needed, overflow uses sign bits.
         assign sum_o[MSB] = a_i[MSB] ^ b_i[MSB] ^ carry[MSB];
      end else begin : g_behav
         assign sum_o = a_i + b_i + {{MSB{1'b0}}, cin_i};
      end
   endgenerate
endmodule

// File: rtl/alu_flag_unit.sv
// Sign-bit logic: overflow of the adder and the corrected less-than bit.
module alu_flag_unit (
   input  logic a_sign_i,
   input  logic b_eff_sign_i,
   input  logic sum_sign_i,
   output logic ovf_o,
   output logic less_o
);
   // With B already conditionally inverted, both add and subtract overflow
   // when the adder inputs agree in sign and the sum disagrees.
   assign ovf_o  = (a_sign_i ~^ b_eff_sign_i) & (sum_sign_i ^ a_sign_i);
   assign less_o = sum_sign_i ^ ovf_o;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] value_i,
   output logic             zero_o
);
   assign zero_o = ~|value_i;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             overflow_o
);
   import alu_pkg::*;

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("alu_core: WIDTH must be at least 2");
      end
   endgenerate

   logic             binvert;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;
   logic             arith_ovf;
   logic             less;

   assign binvert = op_i[2];
   assign b_eff   = b_i ^ {WIDTH{binvert}};

   alu_sum_chain #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_chain (
      .a_i  (a_i),
      .b_i  (b_eff),
      .cin_i(binvert),
      .sum_o(sum)
   );

   alu_flag_unit u_flags (
      .a_sign_i    (a_i[MSB]),
      .b_eff_sign_i(b_eff[MSB]),
      .sum_sign_i  (sum[MSB]),
      .ovf_o       (arith_ovf),
      .less_o      (less)
   );

   always_comb begin
      unique case (op_i)
         ALU_AND:          result_o = a_i & b_i;
         ALU_OR:           result_o = a_i | b_i;
         ALU_ADD, ALU_SUB: result_o = sum;
         ALU_SLT:          result_o = {{MSB{1'b0}}, less};
         default:          result_o = '0;
      endcase
   end

   assign overflow_o = alu_op_arith(op_i) & arith_ovf;

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .value_i(result_o),
      .zero_o (zero_o)
   );
endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
   parameter int unsigned WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o,
   input logic             overflow_o
);
   import alu_pkg::*;
   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      // R6
      zero_flag_chk: assert (zero_o == (result_o == '0))
         else $error("zero flag disagrees with result");
      // R5
      slt_upper_clear_chk: assert (op_i != ALU_SLT || result_o[MSB:1] == '0)
         else $error("slt upper bits not clear");
      // R9
      no_overflow_chk: assert (alu_op_arith(op_i) || !overflow_o)
         else $error("overflow on non-arithmetic op");
      // R10
      unused_op_chk: assert (!(op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
                             || (result_o == '0 && zero_o))
         else $error("unused op gave nonzero result");
      // R7
      add_overflow_chk: assert (!(op_i == ALU_ADD && overflow_o)
                                || (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]))
         else $error("add overflow without sign condition");
      // R8
      sub_overflow_chk: assert (!(op_i == ALU_SUB && overflow_o)
                                || (a_i[MSB] != b_i[MSB] && result_o[MSB] != a_i[MSB]))
         else $error("sub overflow without sign condition");
   end
endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_alu_core_chk (
   .a_i       (a_i),
   .b_i       (b_i),
   .op_i      (op_i),
   .result_o  (result_o),
   .zero_o    (zero_o),
   .overflow_o(overflow_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a, b;
   logic [2:0]  op;
   logic [31:0] result;
   logic        zero, overflow;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   alu_core u_alu_core (
      .a_i(a), .b_i(b), .op_i(op),
      .result_o(result), .zero_o(zero), .overflow_o(overflow)
   );

   function automatic logic [31:0] exp_result(input logic [31:0] x, y, input logic [2:0] o);
      case (o)
         3'b000:  return x & y;
         3'b001:  return x | y;
         3'b010:  return x + y;
         3'b110:  return x - y;
         3'b111:  return {31'd0, ($signed(x) < $signed(y))};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic exp_ovf(input logic [31:0] x, y, input logic [2:0] o);
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(y));
      longint r;
      if (o == 3'b010)      r = sx + sy;
      else if (o == 3'b110) r = sx - sy;
      else                  return 1'b0;
      return (r > 64'sd2147483647) || (r < -64'sd2147483648);
   endfunction

   function automatic string res_tag(input logic [2:0] o);
      case (o)
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b010:  return "R3";
         3'b110:  return "R4";
         3'b111:  return "R5";
         default: return "R10";
      endcase
   endfunction

   function automatic string ovf_tag(input logic [2:0] o);
      case (o)
         3'b010:  return "R7";
         3'b110:  return "R8";
         3'b000, 3'b001, 3'b111: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
      end
   endtask

   // Drive on the falling edge, sample a quarter period later.
   task automatic apply(input logic [31:0] x, y, input logic [2:0] o, input string tag);
      logic [31:0] er;
      @(negedge clk);
      a = x; b = y; op = o;
      #5;
      er = exp_result(x, y, o);
      check((tag != "") ? tag : res_tag(o), result, er);
      check("R6", {31'd0, zero}, {31'd0, (er == 32'd0)});
      check(ovf_tag(o), {31'd0, overflow}, {31'd0, exp_ovf(x, y, o)});
   endtask

   initial begin
      #4000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] ops [8];
      logic [31:0] corners [6];
      ops = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};
      corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001};
      void'($urandom(32'h0A1B_2C3D));
      a = '0; b = '0; op = 3'b000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Quiescent state: all-zero inputs.
      @(negedge clk); #5;
      check("R6", {31'd0, zero}, 32'd1);
      check("R1", result, 32'd0);

      // Directed corner cases.
      apply(32'hF0F0_1234, 32'h0FF0_FF00, 3'b000, "R1");
      apply(32'hF0F0_1234, 32'h0FF0_FF00, 3'b001, "R2");
      apply(32'h7FFF_FFFF, 32'h1,         3'b010, "R7");
      apply(32'h8000_0000, 32'h8000_0000, 3'b010, "R7");
      apply(32'hFFFF_FFFF, 32'h1,         3'b010, "R3");
      apply(32'h8000_0000, 32'h1,         3'b110, "R8");
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R8");
      apply(32'h1234_5678, 32'h1234_5678, 3'b110, "R4");
      apply(32'h1234_5678, 32'h1234_5678, 3'b111, "R5");
      apply(32'h8000_0000, 32'h1,         3'b111, "R11");
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111, "R11");
      apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, "R11");
      apply(32'hFFFF_FFFF, 32'h0,         3'b111, "R5");
      apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b110, "R8");
      apply(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b011, "R10");
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100, "R10");
      apply(32'h8000_0000, 32'h8000_0000, 3'b101, "R10");

      // Corner pairs for every operation code.
      foreach (ops[k]) foreach (corners[i]) foreach (corners[j])
         apply(corners[i], corners[j], ops[k], "");

      // Random pairs, with equal operands mixed in.
      for (int n = 0; n < 300; n++) begin
         foreach (ops[k]) begin
            logic [31:0] x, y;
            x = $urandom();
            y = ($urandom_range(0, 7) == 0) ? x : $urandom();
            apply(x, y, ops[k], "");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule